// File: doc/BRIEF.md
# Host Flag and DMA Handshake Pin Mapper

This block sits between the upper nibble of a general-purpose output port and the four pins that carry it. In its default state it passes the port latch straight to the pins. Two one-cycle enable pulses switch on extra functions, and each stays on until reset. Flag mode turns two of the pins into host interrupt lines: one shows that the output buffer is full, the other that the input buffer can take data. DMA mode turns the other two pins into a request output and an acknowledge input.

The request is set by a port write. It cancels itself when the host finishes a read or a write while the acknowledge input is low. The acknowledge input also selects the data buffers during DMA transfers, in parallel with the ordinary chip select. The host strobes and the acknowledge input arrive without regard to the internal clock, so the block synchronizes them before it looks for the trailing edge of a strobe.

Port latch bit positions, from port bit 4 to port bit 7, map to `portWrData[0]` through `portWrData[3]` and to `pinOut[0]` through `pinOut[3]`.

Top module: `buf_flag_dma_pins`

## Requirements
- R1: After reset both modes are off, the port latch holds 4'b1111, the request is clear and `pinOut` is 4'b1111.
- R2: With a mode off, each pin it governs shows its port latch bit. A write with `portWrEn` high loads `portWrData` into the latch at the next clock edge.
- R3: In flag mode `pinOut[0]` equals `obfStat` when latch bit 0 is 1, and is 0 when latch bit 0 is 0. It follows `obfStat` with no clock delay.
- R4: In flag mode `pinOut[1]` equals the inverse of `ibfStat` when latch bit 1 is 1, and is 0 when latch bit 1 is 0.
- R5: In DMA mode `pinOut[2]` is the request. A port write with bit 2 set raises the request at the next edge. A port write with bit 2 clear leaves the request unchanged.
- R6: When a host read or write strobe (active low) returns high and `ackPinN` was low at the strobe's last low sample, the request falls at the third clock edge after the first cycle in which the strobe is high.
- R7: A strobe that ends while `ackPinN` is high leaves the request set.
- R8: A `dmaModeEn` pulse clears the request at the next edge and wins over a port write that sets the request in the same cycle. A port write that sets the request wins over a strobe clear that falls on the same edge.
- R9: In DMA mode `pinOut[3]` is driven to 1 so the acknowledge line can be read. `effCsN` is `hostCsN & ackPinN` in DMA mode and `hostCsN` otherwise.
- R10: Both modes stay on until reset. A repeated flag enable pulse changes no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low reset |
| portWrEn | input | 1 | Write strobe for the upper port latch |
| portWrData | input | 4 | Latch data, bit 0 = port bit 4 |
| flagModeEn | input | 1 | One-cycle pulse that turns on flag mode |
| dmaModeEn | input | 1 | One-cycle pulse that turns on DMA mode and clears the request |
| ibfStat | input | 1 | Input buffer full status |
| obfStat | input | 1 | Output buffer full status |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| hostCsN | input | 1 | Host chip select, active low |
| ackPinN | input | 1 | DMA acknowledge from the pin, active low |
| pinOut | output | 4 | Values driven on port bits 4 to 7 |
| effCsN | output | 1 | Effective active-low select for the data buffers |

## Verification
Latch and mode changes appear on `pinOut` one edge after the cycle that applies them. Status inputs and chip select pass through the same cycle. The strobe-driven clear lands on the third edge after the strobe returns high. The bench drives each stimulus just after a rising edge and compares one nanosecond later against a model that it advances once per edge. The model keeps a short history of the strobe and acknowledge levels, so it clears the request on exactly the edge that R6 names. Directed sequences check the cycle before and the cycle of each clear, so a clear that comes early or late is reported.

// File: rtl/flag_dma_pkg.sv
package flag_dma_pkg;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int DRQ_BIT = 2;
  localparam int ACK_BIT = 3;

  typedef struct packed {
    logic latchWr;
    logic drqSet;
    logic drqClr;
    logic flagMode;
    logic dmaMode;
  } pin_ctl_t;
endpackage

// File: rtl/pin_mode_ctl.sv
module pin_mode_ctl
  import flag_dma_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     portWrEn,
  input  logic     drqBit,
  input  logic     flagModeEn,
  input  logic     dmaModeEn,
  input  logic     hostRdN,
  input  logic     hostWrN,
  input  logic     ackPinN,
  output pin_ctl_t ctl
);
  localparam int CHAN = 3;
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [CHAN-1:0] rawIn;
  logic [CHAN-1:0] syncNow;
  logic [CHAN-1:0] syncPrev;
  logic flagMode;
  logic dmaMode;
  logic ackedEnd;

  assign rawIn = {ackPinN, hostWrN, hostRdN};

  for (genvar g = 0; g < CHAN; g++) begin : g_sync
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[DEPTH-2:0], rawIn[g]};
    end
    assign syncNow[g]  = pipe[SYNC_STAGES-1];
    assign syncPrev[g] = pipe[SYNC_STAGES];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagMode <= 1'b0;
      dmaMode  <= 1'b0;
    end else begin
      if (flagModeEn) flagMode <= 1'b1;
      if (dmaModeEn)  dmaMode  <= 1'b1;
    end
  end

  // trailing edge of a read or write while acknowledge was held low
  assign ackedEnd = !syncPrev[2] &&
                    ((syncNow[0] && !syncPrev[0]) || (syncNow[1] && !syncPrev[1]));

  always_comb begin
    ctl.latchWr  = portWrEn;
    ctl.drqSet   = portWrEn && dmaMode && drqBit && !dmaModeEn;
    ctl.drqClr   = dmaModeEn || ackedEnd;
    ctl.flagMode = flagMode;
    ctl.dmaMode  = dmaMode;
  end
endmodule

// File: rtl/flag_pin_dp.sv
module flag_pin_dp
  import flag_dma_pkg::*;
#(
  parameter int          NBITS     = 4,
  parameter logic [NBITS-1:0] LATCH_RST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pin_ctl_t         ctl,
  input  logic [NBITS-1:0] portWrData,
  input  logic             ibfStat,
  input  logic             obfStat,
  input  logic             hostCsN,
  input  logic             ackPinN,
  output logic [NBITS-1:0] pinOut,
  output logic             effCsN
);
  logic [NBITS-1:0] portLatch;
  logic             drq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portLatch <= LATCH_RST;
    else if (ctl.latchWr) portLatch <= portWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           drq <= 1'b0;
    else if (ctl.drqSet) drq <= 1'b1;
    else if (ctl.drqClr) drq <= 1'b0;
  end

  always_comb begin
    pinOut = portLatch;
    if (ctl.flagMode) begin
      pinOut[OBF_BIT] = portLatch[OBF_BIT] & obfStat;
      pinOut[IBF_BIT] = portLatch[IBF_BIT] & ~ibfStat;
    end
    if (ctl.dmaMode) begin
      pinOut[DRQ_BIT] = drq;
      pinOut[ACK_BIT] = 1'b1;
    end
    effCsN = ctl.dmaMode ? (hostCsN & ackPinN) : hostCsN;
  end
endmodule

// File: rtl/buf_flag_dma_pins.sv
module buf_flag_dma_pins
  import flag_dma_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portWrEn,
  input  logic [3:0] portWrData,
  input  logic       flagModeEn,
  input  logic       dmaModeEn,
  input  logic       ibfStat,
  input  logic       obfStat,
  input  logic       hostRdN,
  input  logic       hostWrN,
  input  logic       hostCsN,
  input  logic       ackPinN,
  output logic [3:0] pinOut,
  output logic       effCsN
);
  pin_ctl_t ctl;

  pin_mode_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .portWrEn(portWrEn), .drqBit(portWrData[DRQ_BIT]),
    .flagModeEn(flagModeEn), .dmaModeEn(dmaModeEn),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .ackPinN(ackPinN), .ctl(ctl)
  );

  flag_pin_dp #(.NBITS(4), .LATCH_RST(4'b1111)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .portWrData(portWrData),
    .ibfStat(ibfStat), .obfStat(obfStat), .hostCsN(hostCsN),
    .ackPinN(ackPinN), .pinOut(pinOut), .effCsN(effCsN)
  );
endmodule

// File: rtl/flag_dma_pins_chk.sv
module flag_dma_pins_chk (
  input logic       clk,
  input logic       rstN,
  input logic       flagMode,
  input logic       dmaMode,
  input logic       portWrEn,
  input logic [3:0] portWrData,
  input logic       dmaModeEn,
  input logic       obfStat,
  input logic       ackPinN,
  input logic [3:0] pinOut,
  input logic       effCsN
);
  // R3
  obf_pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagMode && !obfStat) |-> !pinOut[0]);
  // R5
  drq_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pinOut[2]) && dmaMode && $past(dmaMode)) |-> $past(portWrEn && portWrData[2]));
  // R8
  drq_clr_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaModeEn |=> !pinOut[2]);
  // R9
  ack_selects_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMode && !ackPinN) |-> !effCsN);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagMode |=> flagMode);
  // R10
  dma_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaMode |=> dmaMode);
endmodule

bind buf_flag_dma_pins flag_dma_pins_chk u_chk (
  .clk(clk), .rstN(rstN), .flagMode(ctl.flagMode), .dmaMode(ctl.dmaMode),
  .portWrEn(portWrEn), .portWrData(portWrData), .dmaModeEn(dmaModeEn),
  .obfStat(obfStat), .ackPinN(ackPinN), .pinOut(pinOut), .effCsN(effCsN)
);

// File: tb/buf_flag_dma_pins_test.sv
`timescale 1ns/1ps
module buf_flag_dma_pins_test;
  logic clk = 0;
  logic rstN = 0;
  logic portWrEn = 0, flagModeEn = 0, dmaModeEn = 0;
  logic [3:0] portWrData = 0;
  logic ibfStat = 0, obfStat = 0, hostRdN = 1, hostWrN = 1, hostCsN = 1, ackPinN = 1;
  logic [3:0] pinOut;
  logic effCsN;

  int nCmp = 0, nBad = 0;
  logic done = 0;

  logic [3:0] mLatch;
  logic mFlag, mDma, mDrq;
  logic [3:0] hRd, hWr, hAck;

  buf_flag_dma_pins uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [3:0] expPins(logic [3:0] lat, logic fl, logic dm, logic dq,
                                         logic ibf, logic obf);
    logic [3:0] p;
    p = lat;
    if (fl) begin p[0] = lat[0] & obf; p[1] = lat[1] & ~ibf; end
    if (dm) begin p[2] = dq; p[3] = 1'b1; end
    return p;
  endfunction

  function automatic logic expCs(logic dm, logic cs, logic ack);
    return dm ? (cs & ack) : cs;
  endfunction

  task automatic check(string tag);
    logic [3:0] ep;
    logic ec;
    ep = expPins(mLatch, mFlag, mDma, mDrq, ibfStat, obfStat);
    ec = expCs(mDma, hostCsN, ackPinN);
    nCmp++;
    if (pinOut !== ep || effCsN !== ec) begin
      nBad++;
      $display("FAIL %s: pinOut=%b effCsN=%b expected pinOut=%b effCsN=%b",
               tag, pinOut, effCsN, ep, ec);
    end
  endtask

  // apply inputs, compare, then advance model over the next edge
  task automatic cyc(string tag, logic we, logic [3:0] wd, logic fe, logic de,
                     logic ibf, logic obf, logic rd, logic wr, logic cs, logic ack);
    logic clr, set;
    portWrEn = we; portWrData = wd; flagModeEn = fe; dmaModeEn = de;
    ibfStat = ibf; obfStat = obf; hostRdN = rd; hostWrN = wr; hostCsN = cs; ackPinN = ack;
    #1;
    check(tag);
    hRd = {hRd[2:0], rd}; hWr = {hWr[2:0], wr}; hAck = {hAck[2:0], ack};
    clr = de || (!hAck[3] && ((hRd[2] && !hRd[3]) || (hWr[2] && !hWr[3])));
    set = we && mDma && wd[2] && !de;
    @(posedge clk);
    if (we) mLatch = wd;
    if (set) mDrq = 1'b1; else if (clr) mDrq = 1'b0;
    if (fe) mFlag = 1'b1;
    if (de) mDma = 1'b1;
    #1;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 4'h0, 0, 0, ibfStat, obfStat, 1, 1, hostCsN, ackPinN);
  endtask

  initial begin
    #200000;
    nBad++;
    $display("FAIL watchdog: run did not end, expected completion");
    done = 1;
  end

  initial begin
    void'($urandom(32'd4242));
    mLatch = 4'hF; mFlag = 0; mDma = 0; mDrq = 0;
    hRd = '1; hWr = '1; hAck = '1;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
    // R1 reset state
    cyc("R1", 0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
    // R2 plain port writes
    cyc("R2", 1, 4'b0101, 0, 0, 1, 1, 1, 1, 0, 1);
    cyc("R2", 1, 4'b1010, 0, 0, 0, 0, 1, 1, 1, 0);
    cyc("R2", 0, 0, 0, 0, 1, 0, 1, 1, 1, 1);
    // R5 request bit is plain before DMA mode
    cyc("R2", 1, 4'b0100, 0, 0, 0, 0, 1, 1, 1, 1);
    // random plain-mode traffic, R2 and R9 chip select
    for (int i = 0; i < 200; i++)
      cyc("R2", $urandom_range(1,0) == 1, 4'($urandom), 0, 0, 1'($urandom), 1'($urandom),
          1, 1, 1'($urandom), 1'($urandom));
    // R3 R4 flag mode
    cyc("R3", 1, 4'b0011, 1, 0, 0, 0, 1, 1, 1, 1);
    cyc("R3", 0, 0, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
    cyc("R4", 0, 0, 0, 0, 1, 0, 1, 1, 1, 1);
    cyc("R4", 1, 4'b0000, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc("R4", 0, 0, 0, 0, 0, 1, 1, 1, 1, 1);
    // R10 repeated flag enable
    cyc("R10", 1, 4'b0011, 1, 0, 1, 1, 1, 1, 1, 1);
    cyc("R10", 0, 0, 1, 0, 1, 1, 1, 1, 1, 1);
    // enter DMA mode, R9 pin3 and chip select
    cyc("R9", 0, 0, 0, 1, 0, 1, 1, 1, 1, 1);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1, 1, 0, 1);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1, 1, 1, 1);
    // R5 set, then zero write leaves it
    cyc("R5", 1, 4'b0111, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc("R5", 1, 4'b0011, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc("R5", 0, 0, 0, 0, 0, 1, 1, 1, 1, 1);
    // R6 acknowledged read clears on third edge
    cyc("R6", 0, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    idle("R6", 3);
    // R6 acknowledged write
    cyc("R6", 1, 4'b0100, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1, 0, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    idle("R6", 5);
    // R7 unacknowledged strobe
    cyc("R7", 1, 4'b0100, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc("R7", 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    cyc("R7", 0, 0, 0, 0, 0, 1, 1, 1, 0, 1);
    idle("R7", 5);
    // R8 enable clears
    cyc("R8", 0, 0, 0, 1, 0, 1, 1, 1, 1, 1);
    idle("R8", 1);
    // R8 enable wins over set
    cyc("R8", 1, 4'b0100, 0, 0, 0, 1, 1, 1, 1, 1);
    cyc("R8", 1, 4'b0100, 0, 1, 0, 1, 1, 1, 1, 1);
    idle("R8", 1);
    // R8 set wins over strobe clear on same edge
    cyc("R8", 0, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    cyc("R8", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    cyc("R8", 0, 0, 0, 0, 0, 1, 1, 1, 1, 0);
    cyc("R8", 1, 4'b0100, 0, 0, 0, 1, 1, 1, 1, 0);
    idle("R8", 3);
    // random DMA and flag traffic, R10 modes stay on
    for (int i = 0; i < 400; i++)
      cyc("R10", $urandom_range(3,0) == 0, 4'($urandom), $urandom_range(15,0) == 0,
          $urandom_range(31,0) == 0, 1'($urandom), 1'($urandom),
          $urandom_range(3,0) != 0, $urandom_range(3,0) != 0, 1'($urandom), 1'($urandom));
    idle("R10", 4);
    done = 1;
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule